// File: doc/BRIEF.md
# Reset Pulse and Phase-Clock Generator

This block runs from a double-rate master clock and turns an active-low reset request into an active-high reset output of guaranteed minimum width. From the same master clock it also produces a half-rate phase clock. The request is treated as a clean digital level from an asynchronous domain, and it is brought into the master-clock domain through a short flop chain before use.

A mode input selects how long the reset pulse must last at minimum. The short width suits a plain restart. The long width leaves room for a downstream self-test. When reset is asserted, the phase clock is restarted from a known level. Reset is then released only on the master-clock edge where the phase clock falls. A receiver that begins its own half-rate phase on the first master-clock cycle after the release therefore runs in step with the phase clock output.

Top module: `rstclk_gen`

## Requirements
- R1: While `rst_n` is low, `reset_out` is 1 and `clk_out` is 0.
- R2: When `reset_out` is low and `req_n` goes low, `reset_out` rises on the third rising edge of `clk2`, counting as the first edge the one that first samples `req_n` low. A request that is low for only one sampled edge is still honoured.
- R3: With `selftest_en` = 0, `reset_out` stays high for at least 15 `clk2` periods.
- R4: With `selftest_en` = 1, `reset_out` stays high for at least 80 `clk2` periods.
- R5: If `req_n` is held low for L sampled edges, `reset_out` stays high for at least L periods.
- R6: On the edge where `reset_out` rises, `clk_out` is forced to 0.
- R7: `reset_out` falls only on an edge where `clk_out` falls from 1 to 0. The pulse width therefore equals the smallest even number that is at least the larger of the mode minimum and L.
- R8: On every other edge after `rst_n` is released, `clk_out` toggles, both during and outside the reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2 | input | 1 | Double-rate master clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| req_n | input | 1 | Active-low reset request, asynchronous to clk2 |
| selftest_en | input | 1 | 1 selects the long minimum width, 0 the short one |
| reset_out | output | 1 | Active-high reset pulse |
| clk_out | output | 1 | Half-rate phase clock |

## Verification
The request is swept over every low duration from one sampled edge up to beyond the long minimum, in both modes. Short requests show that the mode minimum governs the width. Requests longer than the minimum show that the request level governs the width. Odd and even durations show that release waits for the falling phase of the clock. Each pulse also checks the restart level of the clock at assertion, its toggling throughout the pulse, and its level on the two edges around release.

// File: rtl/rstclk_pkg.sv
// Package: shared constants and helpers for the reset/phase-clock generator.
// Assumes: widths are expressed in clk2 periods.
package rstclk_pkg;
    localparam int unsigned SHORT_MIN_DEF = 15;
    localparam int unsigned LONG_MIN_DEF  = 80;
    localparam int unsigned SYNC_DEF      = 2;

    // Pick the minimum pulse width for the selected mode.
    function automatic int unsigned pick_min(input logic long_sel,
                                             input int unsigned short_w,
                                             input int unsigned long_w);
        return long_sel ? long_w : short_w;
    endfunction
endpackage

// File: rtl/rstclk_sync.sv
// Module: flop-chain synchronizer that brings the request level into clk2.
// Assumes: the input is glitch-free; reset value 0 means "request active".
module rstclk_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk2,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture stage.
            always_ff @(posedge clk2) begin
                if (!rst_n) chain <= '0;
                else        chain <= din;
            end
        end else begin : g_many
            // Shift the sampled level through the chain.
            always_ff @(posedge clk2) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rstclk_width.sv
// Module: counts clk2 periods of the reset pulse and flags when the
// mode-selected minimum has been reached.
// Assumes: start pulses on the edge the pulse begins, active is the pulse.
module rstclk_width #(
    parameter int unsigned SHORT_MIN = 15,
    parameter int unsigned LONG_MIN  = 80
) (
    input  logic clk2,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    input  logic long_sel,
    output logic expired
);
    localparam int unsigned CAP = (LONG_MIN > SHORT_MIN) ? LONG_MIN : SHORT_MIN;
    localparam int unsigned CW  = $clog2(CAP + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Select the limit for the current mode.
    always_comb limit = CW'(rstclk_pkg::pick_min(long_sel, SHORT_MIN, LONG_MIN));

    // Count high periods, restarting at 1 on a new pulse, saturating at CAP.
    always_ff @(posedge clk2) begin
        if (!rst_n)                        cnt <= '0;
        else if (start)                    cnt <= CW'(1);
        else if (active && cnt != CW'(CAP)) cnt <= cnt + CW'(1);
    end

    assign expired = (cnt >= limit);

    // R3: a short-mode pulse never ends before SHORT_MIN periods.
    a_r3_short_min: assert property (@(posedge clk2) disable iff (!rst_n)
        ($fell(active) && !$past(long_sel)) |-> ($past(cnt) >= CW'(SHORT_MIN)));
    // R4: a long-mode pulse never ends before LONG_MIN periods.
    a_r4_long_min: assert property (@(posedge clk2) disable iff (!rst_n)
        ($fell(active) && $past(long_sel)) |-> ($past(cnt) >= CW'(LONG_MIN)));
endmodule

// File: rtl/rstclk_phase.sv
// Module: half-rate phase clock, restarted at 0 when a reset pulse begins.
// Assumes: restart is a one-cycle strobe synchronous to clk2.
module rstclk_phase (
    input  logic clk2,
    input  logic rst_n,
    input  logic restart,
    output logic clk_q
);
    // Toggle every edge; force the low phase on restart.
    always_ff @(posedge clk2) begin
        if (!rst_n)       clk_q <= 1'b0;
        else if (restart) clk_q <= 1'b0;
        else              clk_q <= ~clk_q;
    end

    // R8: outside restart edges the clock toggles every edge.
    a_r8_toggle: assert property (@(posedge clk2) disable iff (!rst_n)
        ($past(rst_n) && !$past(restart)) |-> (clk_q != $past(clk_q)));
endmodule

// File: rtl/rstclk_gen.sv
// Module: top of the reset pulse and phase-clock generator.
// Assumes: clk2 is free-running; req_n is a clean asynchronous level;
// selftest_en is stable for the duration of a pulse.
module rstclk_gen #(
    parameter int unsigned SHORT_MIN   = rstclk_pkg::SHORT_MIN_DEF,
    parameter int unsigned LONG_MIN    = rstclk_pkg::LONG_MIN_DEF,
    parameter int unsigned SYNC_STAGES = rstclk_pkg::SYNC_DEF
) (
    input  logic clk2,
    input  logic rst_n,
    input  logic req_n,
    input  logic selftest_en,
    output logic reset_out,
    output logic clk_out
);
    logic req_s;
    logic reset_q;
    logic clk_q;
    logic expired;
    logic begin_evt;
    logic end_evt;

    rstclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk2 (clk2), .rst_n (rst_n), .din (req_n), .dout (req_s)
    );

    rstclk_width #(.SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN)) u_width (
        .clk2 (clk2), .rst_n (rst_n), .start (begin_evt),
        .active (reset_q), .long_sel (selftest_en), .expired (expired)
    );

    rstclk_phase u_phase (
        .clk2 (clk2), .rst_n (rst_n), .restart (begin_evt), .clk_q (clk_q)
    );

    // Decide pulse start and phase-aligned pulse end.
    always_comb begin
        begin_evt = !reset_q && !req_s;
        end_evt   = reset_q && req_s && expired && clk_q;
    end

    // Hold the reset pulse state.
    always_ff @(posedge clk2) begin
        if (!rst_n)         reset_q <= 1'b1;
        else if (begin_evt) reset_q <= 1'b1;
        else if (end_evt)   reset_q <= 1'b0;
    end

    assign reset_out = reset_q;
    assign clk_out   = clk_q;

    // R2: a synchronized request starts the pulse on the next edge.
    a_r2_start: assert property (@(posedge clk2) disable iff (!rst_n)
        (!reset_q && !req_s) |=> reset_q);
    // R5: the pulse is held while the synchronized request is low.
    a_r5_hold: assert property (@(posedge clk2) disable iff (!rst_n)
        (reset_q && !req_s) |=> reset_q);
    // R6: the phase clock is low right after the pulse begins.
    a_r6_restart: assert property (@(posedge clk2) disable iff (!rst_n)
        ($rose(reset_q) && $past(rst_n)) |-> !clk_q);
    // R7: release coincides with the phase clock falling.
    a_r7_aligned: assert property (@(posedge clk2) disable iff (!rst_n)
        $fell(reset_q) |-> $fell(clk_q));
endmodule

// File: tb/sim_rstclk_gen.sv
module sim_rstclk_gen;
    logic clk2 = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1;
    logic selftest_en = 1'b0;
    logic reset_out;
    logic clk_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk2 = ~clk2;

    rstclk_gen u0 (
        .clk2 (clk2), .rst_n (rst_n), .req_n (req_n),
        .selftest_en (selftest_en), .reset_out (reset_out), .clk_out (clk_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One pulse: request low for len sampled edges in the given mode.
    task automatic run_pulse(input bit mode, input int len);
        int k;
        int rise_k;
        int width;
        int exp_w;
        int minw;
        bit prev_clk;
        bit tog_ok;
        @(negedge clk2);
        selftest_en = mode;
        req_n = 1'b0;
        k = 0;
        rise_k = -1;
        width = 0;
        tog_ok = 1;
        prev_clk = 0;
        while (1) begin
            @(negedge clk2);
            if (k == len - 1) req_n = 1'b1;
            if (reset_out) begin
                if (rise_k < 0) begin
                    rise_k = k;
                    check(clk_out == 1'b0, "R6", clk_out, 0);
                end else if (clk_out == prev_clk) tog_ok = 0;
                width++;
                prev_clk = clk_out;
            end else if (rise_k >= 0) begin
                break;
            end
            k++;
            if (k > 400) break;
        end
        check(rise_k == 2, "R2", rise_k, 2);
        minw = mode ? 80 : 15;
        exp_w = (minw > len) ? minw : len;
        if (exp_w % 2 == 1) exp_w++;
        check(width >= minw, mode ? "R4" : "R3", width, minw);
        check(width >= len, "R5", width, len);
        check(width == exp_w, "R7", width, exp_w);
        check(clk_out == 1'b0, "R7", clk_out, 0);
        check(tog_ok, "R8", tog_ok, 1);
        @(negedge clk2);
        check(clk_out == 1'b1 && reset_out == 1'b0, "R8", clk_out, 1);
        repeat (3) @(negedge clk2);
    endtask

    initial begin
        repeat (3) @(negedge clk2);
        check(reset_out == 1'b1, "R1", reset_out, 1);
        check(clk_out == 1'b0, "R1", clk_out, 0);
        rst_n = 1'b1;
        repeat (100) @(negedge clk2);
        check(reset_out == 1'b0, "R1", reset_out, 0);
        for (int m = 0; m < 2; m++) begin
            for (int len = 1; len <= 92; len++) begin
                run_pulse(m[0], len);
            end
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk2);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule